// File: doc/BRIEF.md
# Interval Timer Compare Unit

A per-core interval timer: a free-running cycle counter and a 32-bit compare register that share one register address. A read of that address always returns the full counter. A write to it never touches the counter; it only loads the compare register, which has no read path. When the low 32 bits of the counter equal the compare value, a sticky pending flag is set. The interrupt output is that flag gated by a mask input. A separate clear input drops the flag.

Software schedules the next interrupt by reading the counter, adding an interval and writing the sum back as the compare value. Each instance counts on its own clock and has no link to any other instance. The counter is 32 or 64 bits wide, chosen by a parameter. With a 64-bit counter only the low word takes part in the match.

Top module: `interval_compare_timer`

## Requirements
- R1: After reset the counter reads 0. It then increases by exactly one on every clock cycle and wraps modulo 2^CNT_W.
- R2: CNT_W is 32 or 64, and any other value stops elaboration. `rd_data` always returns the full CNT_W-bit counter, and a write (`wr_en` high) leaves the counter sequence unchanged.
- R3: The compare register resets to 32'hFFFF_FFFF. A write loads bits [31:0] of `wr_data` into it at the clock edge and discards any higher bits. It holds its value when there is no write.
- R4: When counter bits [31:0] equal the compare register during a cycle, the pending flag is set at the end of that cycle, so `irq` (with mask low) rises one cycle after the equality.
- R5: Once set, the pending flag stays set until `pend_clr` is high at a clock edge. It is then cleared, unless R7 applies.
- R6: `irq` is high exactly when the flag is pending and `irq_mask` is low. Masking hides the interrupt without clearing the flag, so `irq` reappears in the same cycle the mask drops.
- R7: If `pend_clr` and a match fall in the same cycle, the match wins and the flag remains set.
- R8: A compare value that the counter's low word has already passed raises nothing until the low word wraps. A further match while the flag is pending leaves it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the shared timer address (loads compare) |
| wr_data | input | CNT_W | Write data; only bits [31:0] are kept |
| rd_data | output | CNT_W | Read data of the shared timer address (the counter) |
| irq_mask | input | 1 | High masks the interrupt output |
| pend_clr | input | 1 | High at an edge clears the pending flag |
| irq | output | 1 | Maskable interrupt request |

## Verification
The assertions assume that reset is held low through the first clock edge. They also assume that no run lasts long enough for the low counter word to wrap, so in the scenarios covered a compare value is matched at most once. The stimulus respects both limits: reset spans several edges, and each run is far shorter than 2^32 cycles. The stimulus changes the mask, the clear and the write strobe only between edges, and it places compare targets a known number of cycles ahead of (or behind) the counter. That lets every match cycle be predicted exactly.

// File: rtl/itc_pkg.sv
package itc_pkg;
   localparam int unsigned CMP_W = 32;
   localparam logic [CMP_W-1:0] CMP_RESET = {CMP_W{1'b1}};

   function automatic bit width_ok(int unsigned w);
      return (w == 32) || (w == 64);
   endfunction
endpackage

// File: rtl/itc_free_counter.sv
module itc_free_counter #(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] count
);
   import itc_pkg::*;
   localparam int unsigned HI_W = (CNT_W > CMP_W) ? CNT_W - CMP_W : 1;

   logic [CMP_W-1:0] lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lo_q <= '0;
      else        lo_q <= lo_q + 1'b1;
   end

   generate
      if (CNT_W > CMP_W) begin : g_split
         logic [HI_W-1:0] hi_q;
         logic            lo_full;
         assign lo_full = &lo_q;
         always_ff @(posedge clk) begin
            if (!rst_n)       hi_q <= '0;
            else if (lo_full) hi_q <= hi_q + 1'b1;
         end
         assign count = {hi_q, lo_q};
      end else begin : g_flat
         assign count = lo_q;
      end
   endgenerate
endmodule

// File: rtl/itc_compare_reg.sv
module itc_compare_reg #(
   parameter int unsigned CNT_W = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [CNT_W-1:0]         wr_data,
   input  logic [CNT_W-1:0]         count,
   output logic [itc_pkg::CMP_W-1:0] cmp_val,
   output logic                     hit
);
   import itc_pkg::*;

   logic [CMP_W-1:0] wr_low;
   logic [CMP_W-1:0] cnt_low;
   logic [CMP_W-1:0] cmp_q;

   generate
      if (CNT_W > CMP_W) begin : g_trunc
         assign wr_low  = wr_data[CMP_W-1:0];
         assign cnt_low = count[CMP_W-1:0];
      end else begin : g_direct
         assign wr_low  = wr_data;
         assign cnt_low = count;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     cmp_q <= CMP_RESET;
      else if (wr_en) cmp_q <= wr_low;
   end

   assign cmp_val = cmp_q;
   assign hit     = (cnt_low == cmp_q);
endmodule

// File: rtl/itc_pending_latch.sv
module itc_pending_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic mask_i,
   output logic pend_o,
   output logic irq_o
);
   logic pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     pend_q <= 1'b0;
      else if (set_i) pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
   end

   assign pend_o = pend_q;
   assign irq_o  = pend_q & ~mask_i;
endmodule

// File: rtl/interval_compare_timer.sv
module interval_compare_timer #(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] rd_data,
   input  logic             irq_mask,
   input  logic             pend_clr,
   output logic             irq
);
   import itc_pkg::*;

   generate
      if (!width_ok(CNT_W)) begin : g_bad_width
         $error("interval_compare_timer: CNT_W must be 32 or 64");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CMP_W-1:0] cmp_q;
   logic             hit;
   logic             pend_q;

   itc_free_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .count (cnt_q)
   );

   itc_compare_reg #(.CNT_W(CNT_W)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .count   (cnt_q),
      .cmp_val (cmp_q),
      .hit     (hit)
   );

   itc_pending_latch u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (hit),
      .clr_i  (pend_clr),
      .mask_i (irq_mask),
      .pend_o (pend_q),
      .irq_o  (irq)
   );

   assign rd_data = cnt_q;
endmodule

// File: rtl/itc_checker.sv
module itc_checker #(
   parameter int unsigned CNT_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [CNT_W-1:0] wr_data,
   input logic [CNT_W-1:0] rd_data,
   input logic             irq_mask,
   input logic             pend_clr,
   input logic             irq,
   input logic [31:0]      cmp_q,
   input logic             pend_q
);
   assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> rd_data == $past(rd_data) + 1'b1);

   assert_write_no_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data == $past(rd_data) + 1'b1);

   assert_cmp_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cmp_q == $past(wr_data[31:0]));

   assert_cmp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cmp_q));

   assert_match_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[31:0] == cmp_q) |=> pend_q);

   assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !pend_clr) |=> pend_q);

   assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mask |-> !irq);

   assert_irq_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> pend_q);

   assert_clr_race_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_clr && rd_data[31:0] == cmp_q) |=> pend_q);

   assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(pend_q) && $past(rd_data[31:0]) != $past(cmp_q)) |-> !pend_q);
endmodule

bind interval_compare_timer itc_checker #(.CNT_W(CNT_W)) u_itc_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .rd_data  (rd_data),
   .irq_mask (irq_mask),
   .pend_clr (pend_clr),
   .irq      (irq),
   .cmp_q    (cmp_q),
   .pend_q   (pend_q)
);

// File: tb/tb_interval_compare_timer.sv
`timescale 1ns/1ps
module tb_interval_compare_timer;
   localparam int unsigned CNT_W = 64;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [CNT_W-1:0] wr_data = '0;
   logic [CNT_W-1:0] rd_data;
   logic             irq_mask = 1'b0;
   logic             pend_clr = 1'b0;
   logic             irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   interval_compare_timer #(.CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .irq_mask(irq_mask), .pend_clr(pend_clr), .irq(irq)
   );

   // Arithmetic reference built from the requirements
   logic [CNT_W-1:0] m_cnt;
   logic [31:0]      m_cmp;
   logic             m_pend;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt  <= '0;
         m_cmp  <= 32'hFFFF_FFFF;
         m_pend <= 1'b0;
      end else begin
         m_cnt <= m_cnt + 1'b1;
         if (wr_en) m_cmp <= wr_data[31:0];
         if (m_cnt[31:0] == m_cmp) m_pend <= 1'b1;
         else if (pend_clr)        m_pend <= 1'b0;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one cycle: sample at negedge, then release single-cycle strobes
   task automatic cyc(input string req);
      @(negedge clk);
      check({req, " count"}, rd_data, m_cnt);
      check({req, " irq"}, irq, m_pend & ~irq_mask);
      wr_en = 1'b0;
      pend_clr = 1'b0;
   endtask

   task automatic clear_pend();
      pend_clr = 1'b1;
      cyc("R5");
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset count", rd_data, 0);
      check("R6 reset irq", irq, 0);
      rst_n = 1'b1;
      // R1/R3: counting from zero; compare resets to all ones so no early irq
      for (int i = 0; i < 300; i++) cyc("R1_R3");
      check("R3 no early irq", irq, 0);

      // R4: offset sweep, exact rise cycle
      for (int d = 1; d <= 40; d++) begin
         logic [31:0] tgt;
         @(negedge clk);
         tgt = m_cnt[31:0] + 32'(d);
         wr_data = {32'h0, tgt};
         wr_en = 1'b1;
         while (rd_data[31:0] != tgt) cyc("R2_R4");
         check("R4 before rise", irq, 0);
         cyc("R4");
         check("R4 rise", irq, 1);
         for (int k = 0; k < 3; k++) cyc("R5");
         check("R5 sticky", irq, 1);
         clear_pend();
         check("R5 cleared", irq, 0);
      end

      // R3: upper write bits dropped
      begin
         logic [31:0] tgt;
         @(negedge clk);
         tgt = m_cnt[31:0] + 32'd9;
         wr_data = {32'hDEAD_BEEF, tgt};
         wr_en = 1'b1;
         while (rd_data[31:0] != tgt) cyc("R3");
         cyc("R3");
         check("R3 truncated match", irq, 1);
         clear_pend();
      end

      // R6: mask hides, not clears
      begin
         logic [31:0] tgt;
         @(negedge clk);
         irq_mask = 1'b1;
         tgt = m_cnt[31:0] + 32'd6;
         wr_data = {32'h0, tgt};
         wr_en = 1'b1;
         for (int k = 0; k < 15; k++) cyc("R6");
         check("R6 masked", irq, 0);
         irq_mask = 1'b0;
         #1;
         check("R6 unmask shows pending", irq, 1);
         clear_pend();
      end

      // R7: clear in the match cycle loses to the match
      begin
         logic [31:0] tgt;
         @(negedge clk);
         tgt = m_cnt[31:0] + 32'd8;
         wr_data = {32'h0, tgt};
         wr_en = 1'b1;
         while (rd_data[31:0] != tgt) cyc("R7");
         pend_clr = 1'b1;
         cyc("R7");
         check("R7 set wins", irq, 1);
         clear_pend();
      end

      // R8: target already passed; and second match while pending
      begin
         @(negedge clk);
         wr_data = {32'h0, m_cnt[31:0] - 32'd5};
         wr_en = 1'b1;
         for (int k = 0; k < 200; k++) cyc("R8");
         check("R8 passed target silent", irq, 0);
      end
      begin
         logic [31:0] tgt;
         @(negedge clk);
         tgt = m_cnt[31:0] + 32'd4;
         wr_data = {32'h0, tgt};
         wr_en = 1'b1;
         for (int k = 0; k < 10; k++) cyc("R8");
         wr_data = {32'h0, m_cnt[31:0] + 32'd3};
         wr_en = 1'b1;
         for (int k = 0; k < 10; k++) cyc("R8");
         check("R8 still pending", irq, 1);
         clear_pend();
         check("R8 cleared", irq, 0);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule